// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block holds the 32-bit interrupt control word of a DMA controller. The word has three kinds of field. Some are plain read/write: six low spare bits, a bus-error bit, seven per-channel enables and one global enable. Seven per-channel completion flags are set by hardware and cleared by software, which writes a 1 to a flag. The top bit is a computed master flag. Each DMA channel gives a one-cycle completion pulse. The block keeps the word current and reports the whole word every cycle. It also raises a single interrupt pulse toward the system interrupt controller, which routes it to status bit 3.

The master flag is handled by a two-state machine. In `ST_QUIET` the master bit reads 0. In `ST_SENT` it reads 1. The transition `QUIET->SENT` (named `arm`) happens when the updated word meets the master condition. This is the only transition that emits the interrupt pulse. The transition `SENT->QUIET` (named `release`) happens when the condition no longer holds after an update. `SENT->SENT` (named `hold`) keeps the bit set without a new pulse. `QUIET->QUIET` (named `idle`) keeps it clear. Software writes always cover the full 32-bit word.

Top module: `dma_irq_ctl`

## Requirements
- R1: After reset the whole word reads 0x00000000 and the interrupt output is 0.
- R2: A write loads bits 0..5, bit 15 (bus error) and bits 16..23 (bit 16+n enables channel n, bit 23 is the global enable) from the written value, in the same update. Bits 6..14 always read 0.
- R3: Flag bit 24+n is write-1-to-clear. A write with 1 at 24+n clears it. A write with 0 there leaves it unchanged.
- R4: A completion pulse on channel n sets flag 24+n only if enable bit 16+n is 1 after that cycle's write. A pulse arriving with a clearing write for the same flag leaves the flag set. Pulses for disabled channels leave the word unchanged.
- R5: Bit 31 reads 1 exactly when the word's global enable bit 23 is set together with any flag in bits 24..30, or when bus-error bit 15 is set.
- R6: The interrupt output is a one-cycle pulse. It goes high in the same cycle that bit 31 goes from 0 to 1, and never while bit 31 stays 1.
- R7: When an update leaves the master condition false, bit 31 clears. A later event that makes the condition true again raises a new pulse.
- R8: Flags that are set while the global enable is 0 raise no interrupt. A later write that sets the global enable raises one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full-word software write strobe |
| wr_data | input | 32 | Written value |
| ch_done | input | 7 | Per-channel completion pulses, bit n for channel n |
| ctl_word | output | 32 | Current register contents |
| irq_pulse | output | 1 | One-cycle interrupt request toward status bit 3 |

## Verification
The bench drives three kinds of stimulus against a behavioural model.

An all-ones write shows that only the writable mask is loaded and that the bus error raises the master flag by itself. Targeted sequences separate several cases: an enabled pulse from a disabled one, a clearing write from a keeping write, and a pulse that collides with its own clear. Other sequences trigger the master flag twice, once through the flag path and once by turning on the global enable late. Together they show whether a pulse comes only on the 0-to-1 edge of bit 31.

A long stretch of random writes and pulses then compares the full word and the interrupt output on every clock.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int WORD_W    = 32;
    localparam int MAX_CH    = 7;
    localparam int SPARE_W   = 6;
    localparam int EN_LSB    = 16;
    localparam int EN_W      = 8;
    localparam int GEN_BIT   = 23;
    localparam int BUSERR_BIT = 15;
    localparam int FLAG_LSB  = 24;
    localparam int MASTER_BIT = 31;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_SENT  = 1'b1
    } master_st_e;
endpackage

// File: rtl/dma_irq_fields.sv
module dma_irq_fields
    import dma_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [SPARE_W-1:0]   spare_q,
    output logic                 buserr_q,
    output logic [EN_W-1:0]      en_q,
    output logic                 buserr_d,
    output logic [EN_W-1:0]      en_d
);
    logic [SPARE_W-1:0] spare_d;

    always_comb begin
        spare_d  = wr_en ? wr_data[SPARE_W-1:0]         : spare_q;
        buserr_d = wr_en ? wr_data[BUSERR_BIT]          : buserr_q;
        en_d     = wr_en ? wr_data[EN_LSB +: EN_W]      : en_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q  <= '0;
            buserr_q <= 1'b0;
            en_q     <= '0;
        end else begin
            spare_q  <= spare_d;
            buserr_q <= buserr_d;
            en_q     <= en_d;
        end
    end

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wr_data[EN_LSB +: EN_W])) && (buserr_q == $past(wr_data[BUSERR_BIT])));
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
    import dma_irq_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NCH-1:0]    ch_done,
    input  logic [EN_W-1:0]   en_d,
    output logic [NCH-1:0]    flag_q,
    output logic [NCH-1:0]    flag_d
);
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic kept;
        logic hit;
        always_comb begin
            kept      = flag_q[n] && !(wr_en && wr_data[FLAG_LSB + n]);
            hit       = ch_done[n] && en_d[n];
            flag_d[n] = kept || hit;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[n] <= 1'b0;
            else        flag_q[n] <= flag_d[n];
        end

        // R4
        no_flag_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[n] && !(ch_done[n] && en_d[n])) |=> !flag_q[n]);
        // R3
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[FLAG_LSB + n] && !ch_done[n]) |=> !flag_q[n]);
    end
endmodule

// File: rtl/dma_irq_master_fsm.sv
module dma_irq_master_fsm
    import dma_irq_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gen_d,
    input  logic           buserr_d,
    input  logic [NCH-1:0] flag_d,
    output logic           master_q,
    output logic           irq_pulse
);
    master_st_e state_q, state_d;
    logic       cond;

    always_comb cond = (gen_d && (|flag_d)) || buserr_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (cond)  state_d = ST_SENT;   // arm
            ST_SENT:  if (!cond) state_d = ST_QUIET;  // release
            default:             state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            unique case (state_q)
                ST_QUIET: irq_pulse <= cond;
                ST_SENT:  irq_pulse <= 1'b0;
                default:  irq_pulse <= 1'b0;
            endcase
        end
    end

    always_comb master_q = (state_q == ST_SENT);

    // R6
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    // R6
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (master_q && !$past(master_q)));
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
    import dma_irq_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [NCH-1:0]    ch_done,
    output logic [31:0]       ctl_word,
    output logic              irq_pulse
);
    localparam int UNUSED_FLAGS = MAX_CH - NCH;

    logic [SPARE_W-1:0] spare_q;
    logic               buserr_q, buserr_d;
    logic [EN_W-1:0]    en_q, en_d;
    logic [NCH-1:0]     flag_q, flag_d;
    logic               master_q;

    dma_irq_fields u_fields (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .spare_q(spare_q), .buserr_q(buserr_q), .en_q(en_q),
        .buserr_d(buserr_d), .en_d(en_d)
    );

    dma_irq_flags #(.NCH(NCH)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ch_done(ch_done), .en_d(en_d), .flag_q(flag_q), .flag_d(flag_d)
    );

    dma_irq_master_fsm #(.NCH(NCH)) u_master (
        .clk(clk), .rst_n(rst_n), .gen_d(en_d[GEN_BIT-EN_LSB]),
        .buserr_d(buserr_d), .flag_d(flag_d),
        .master_q(master_q), .irq_pulse(irq_pulse)
    );

    always_comb begin
        ctl_word                         = '0;
        ctl_word[SPARE_W-1:0]            = spare_q;
        ctl_word[BUSERR_BIT]             = buserr_q;
        ctl_word[EN_LSB +: EN_W]         = en_q;
        ctl_word[FLAG_LSB +: NCH]        = flag_q;
        ctl_word[MASTER_BIT]             = master_q;
    end

    initial begin
        if (UNUSED_FLAGS < 0) $error("NCH exceeds the flag field");
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word[14:6] == '0);
    // R5
    master_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word[MASTER_BIT] == ((ctl_word[GEN_BIT] && (|ctl_word[30:24])) || ctl_word[BUSERR_BIT]));
endmodule

// File: tb/dma_irq_ctl_tb.sv
module dma_irq_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  ch_done = '0;
    logic [31:0] ctl_word;
    logic        irq_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] m_word = '0;
    logic        m_irq  = 1'b0;

    always #10 clk = ~clk;

    dma_irq_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ch_done(ch_done), .ctl_word(ctl_word), .irq_pulse(irq_pulse)
    );

    task automatic cmp(string tag);
        checks++;
        if (ctl_word !== m_word || irq_pulse !== m_irq) begin
            fails++;
            $display("FAIL %s: word=%h irq=%b expected word=%h irq=%b",
                     tag, ctl_word, irq_pulse, m_word, m_irq);
        end
    endtask

    // Behavioural model of one update
    task automatic step(input bit w, input logic [31:0] d, input logic [6:0] p, input string tag);
        logic [31:0] v;
        bit master;
        @(negedge clk);
        wr_en = w; wr_data = d; ch_done = p;
        @(posedge clk);
        v = m_word & 32'h7FFF_FFFF;
        if (w) v = (d & 32'h00FF_803F) | (v & ~d & 32'h7F00_0000);
        for (int n = 0; n < 7; n++)
            if (p[n] && v[16+n]) v[24+n] = 1'b1;
        master = (v[23] && (v[30:24] != 0)) || v[15];
        m_irq  = master && !m_word[31];
        v[31]  = master;
        m_word = v;
        #1;
        cmp(tag);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: word=%h irq=%b expected completion", ctl_word, irq_pulse);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; cmp("R1 reset value");
        @(negedge clk); rst_n = 1'b1;
        #1; cmp("R1 idle after reset");

        step(1, 32'hFFFF_FFFF, 7'h00, "R2 all-ones write, R5 bus error master");
        step(0, 32'h0, 7'h00, "R6 pulse is one cycle");
        step(1, 32'h0000_0000, 7'h00, "R7 clear releases master");
        step(1, 32'h0083_0015, 7'h00, "R2 enable load");
        step(0, 32'h0, 7'h01, "R4 enabled pulse sets flag, R6 irq");
        step(0, 32'h0, 7'h02, "R6 no second pulse while set");
        step(0, 32'h0, 7'h04, "R4 disabled channel ignored");
        step(1, 32'h0183_0015, 7'h00, "R3 clear one flag keep other");
        step(1, 32'h0283_0015, 7'h00, "R7 last flag cleared");
        step(0, 32'h0, 7'h02, "R7 new event raises new pulse");
        step(1, 32'h0283_0015, 7'h02, "R4 pulse beats its own clear");
        step(1, 32'h0203_0000, 7'h01, "R8 global enable off releases");
        step(0, 32'h0, 7'h02, "R8 flags without global enable");
        step(1, 32'h0083_0000, 7'h00, "R8 late global enable raises irq");
        step(1, 32'h7F00_8000, 7'h00, "R5 bus error alone keeps master");
        step(1, 32'h0000_0000, 7'h00, "R7 bus error cleared");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            d = $urandom;
            if ($urandom_range(3) != 0) d[15] = 1'b0;
            step(($urandom_range(3) == 0), d, 7'($urandom), "R5 random mix");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule